// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block drives one serial test bit per enabled transmit clock. It has two modes. In pseudorandom mode a shift register of programmable length (1 to 32 stages) runs with two feedback taps. One tap is fixed at the last stage. The other is chosen by a 5-bit field, so a single configuration word can describe any two-tap polynomial. In repetitive mode the same register rotates a user word of 1 to 32 bits without feedback.

A clock enable gates the pattern for fractional or gapped channels. A reload input restarts the pattern from the seed word with a fixed two-clock latency. The outgoing stream can be inverted. Bit errors can be injected at a selectable decimal rate, or one at a time on request. An injected error changes only the bit on the line and never the register contents, so the pattern resumes unchanged after it.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While reset is asserted and after it is released, `tx_data` is 0 until the first enabled bit is produced.
- R2: In pseudorandom mode (`cfg_repeat`=0) with length L=`cfg_len_m1`+1, the output bit is stage L-1. On each enabled clock, stage 0 receives stage L-1 XOR stage `cfg_tap`, and every other stage i takes the old stage i-1.
- R3: In repetitive mode (`cfg_repeat`=1) the output after a reload is seed bit L-1, then L-2, down to bit 0, and this repeats with period L.
- R4: A rising edge of `reload` first sampled at clock edge k loads the seed at edge k+1. With `clk_en` high, the first bit of the new pattern is on `tx_data` after edge k+2.
- R5: In pseudorandom mode a seed whose lowest L bits are all zero is loaded as the value 1, so the register cannot lock up.
- R6: While `clk_en` is low, `tx_data` and the pattern position hold. Only enabled clocks advance the pattern.
- R7: With `cfg_invert`=1 every output bit is the complement of the pattern bit.
- R8: `cfg_rate`=k (1..7) flips every 10^k-th enabled bit, counted from the last reload, so bit indices 10^k-1, 2*10^k-1 and so on are flipped. `cfg_rate`=0 inserts no automatic errors.
- R9: A one-cycle `err_req` pulse flips exactly the next enabled output bit. The request is held while `clk_en` is low.
- R10: An injected error does not disturb the register, so the bits after it follow the error-free sequence.
- R11: When a pending single request and an automatic error fall on the same bit, that bit is flipped once and the request is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Gap-clock enable; the pattern advances only when high |
| reload | input | 1 | Rising edge restarts the pattern from the seed |
| cfg_repeat | input | 1 | 0 = pseudorandom, 1 = repetitive word |
| cfg_len_m1 | input | 5 | Pattern length minus one |
| cfg_tap | input | 5 | Stage index of the programmable feedback tap |
| cfg_seed | input | 32 | Seed / repetitive word |
| cfg_rate | input | 3 | Automatic error rate, 1 in 10^code; 0 = off |
| cfg_invert | input | 1 | Invert the outgoing data |
| err_req | input | 1 | Request for one error on the next enabled bit |
| tx_data | output | 1 | Serial pattern output |

## Verification
The automatic decimal-rate injector and the single-error request can both target the same output bit. The bench provokes this with a rate of 1 in 10 on an all-zero repetitive word. It times a request pulse so that the request is pending exactly when bit index 9 is produced. It then counts the ones over 20 bits: two ones show a single combined flip with the request consumed, and a third one would show a double count or a leftover request. A behavioural model that runs every cycle also judges each bit in this window and in all other phases.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

    typedef enum logic {
        MODE_PRBS   = 1'b0,
        MODE_REPEAT = 1'b1
    } pat_mode_e;

    // 10 raised to k, k limited to 0..9 (fixed loop bound for synthesis)
    function automatic logic [31:0] pow10(input int k);
        logic [31:0] r;
        r = 32'd1;
        for (int j = 0; j < 9; j++) begin
            if (j < k) r = r * 32'd10;
        end
        return r;
    endfunction

endpackage

// File: rtl/pattern_shift_core.sv
module pattern_shift_core
    import prbs_gen_pkg::*;
#(
    parameter int W  = 32,
    parameter int LW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          load_i,
    input  pat_mode_e     mode_i,
    input  logic [LW-1:0] len_m1_i,
    input  logic [LW-1:0] tap_i,
    input  logic [W-1:0]  seed_i,
    output logic          head_o
);

    typedef struct packed {
        logic [W-1:0] sr;
    } core_state_t;

    core_state_t s_d, s_q;
    logic [W-1:0] mask;
    logic         fb;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (LW'(i) <= len_m1_i);
        end
        head_o = s_q.sr[len_m1_i];
        fb     = (mode_i == MODE_REPEAT) ? head_o : (head_o ^ s_q.sr[tap_i]);
        s_d    = s_q;
        if (load_i) begin
            s_d.sr = seed_i & mask;
            if ((mode_i == MODE_PRBS) && (s_d.sr == '0)) begin
                s_d.sr = {{(W-1){1'b0}}, 1'b1};
            end
        end else if (step_i) begin
            s_d.sr = {s_q.sr[W-2:0], fb};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R5: a pseudorandom load never leaves the active stages all zero
    assert_seed_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i == MODE_PRBS) |=> ((s_q.sr & $past(mask)) != '0));

    // R3: rotation in repetitive mode keeps the number of ones in the word
    assert_rotate_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && mode_i == MODE_REPEAT)
        |=> ($countones(s_q.sr & $past(mask)) == $past($countones(s_q.sr & mask))));

endmodule

// File: rtl/err_injector.sv
module err_injector
    import prbs_gen_pkg::*;
#(
    parameter int MAX_RATE = 7,
    parameter int RW       = $clog2(MAX_RATE + 1),
    parameter int CW       = $clog2(pow10(MAX_RATE))
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          clear_i,
    input  logic [RW-1:0] rate_i,
    input  logic          req_i,
    output logic          flip_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } inj_state_t;

    inj_state_t    s_d, s_q;
    logic [CW-1:0] lim;
    logic          auto_hit;

    always_comb begin
        lim      = CW'(pow10(int'(rate_i)));
        auto_hit = (rate_i != '0) && (s_q.cnt >= lim - CW'(1));
        flip_o   = auto_hit | s_q.pend;
        s_d      = s_q;
        s_d.pend = req_i | (s_q.pend & ~step_i);
        if (step_i) begin
            s_d.cnt = auto_hit ? '0 : s_q.cnt + CW'(1);
        end
        if (clear_i || rate_i == '0) begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R9: an enabled bit consumes the pending request unless a new one arrives
    assert_req_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !req_i) |=> !s_q.pend);

    // R8: after an automatic error the interval count restarts
    assert_rate_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && auto_hit) |=> (s_q.cnt == '0));

endmodule

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen
    import prbs_gen_pkg::*;
#(
    parameter int W        = 32,
    parameter int LW       = $clog2(W),
    parameter int MAX_RATE = 7,
    parameter int RW       = $clog2(MAX_RATE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          reload,
    input  logic          cfg_repeat,
    input  logic [LW-1:0] cfg_len_m1,
    input  logic [LW-1:0] cfg_tap,
    input  logic [W-1:0]  cfg_seed,
    input  logic [RW-1:0] cfg_rate,
    input  logic          cfg_invert,
    input  logic          err_req,
    output logic          tx_data
);

    typedef struct packed {
        logic rl1;
        logic rl2;
        logic tx;
    } top_state_t;

    top_state_t s_d, s_q;
    logic       load_pulse;
    logic       head;
    logic       flip;
    pat_mode_e  mode;

    assign mode    = pat_mode_e'(cfg_repeat);
    assign tx_data = s_q.tx;

    pattern_shift_core #(.W(W), .LW(LW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (clk_en),
        .load_i   (load_pulse),
        .mode_i   (mode),
        .len_m1_i (cfg_len_m1),
        .tap_i    (cfg_tap),
        .seed_i   (cfg_seed),
        .head_o   (head)
    );

    err_injector #(.MAX_RATE(MAX_RATE), .RW(RW)) u_inj (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (clk_en),
        .clear_i (load_pulse),
        .rate_i  (cfg_rate),
        .req_i   (err_req),
        .flip_o  (flip)
    );

    always_comb begin
        load_pulse = s_q.rl1 & ~s_q.rl2;
        s_d        = s_q;
        s_d.rl1    = reload;
        s_d.rl2    = s_q.rl1;
        if (clk_en) begin
            s_d.tx = head ^ cfg_invert ^ flip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: a gapped clock leaves the line unchanged
    assert_gap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(tx_data));

    // R7: without an error the line carries the pattern bit, inverted on request
    assert_clean_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !flip) |=> (tx_data == $past(head ^ cfg_invert)));

endmodule

// File: tb/tb_prbs_pattern_gen.sv
module tb_prbs_pattern_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        reload = 1'b0;
    logic        cfg_repeat = 1'b0;
    logic [4:0]  cfg_len_m1 = 5'd6;
    logic [4:0]  cfg_tap = 5'd5;
    logic [31:0] cfg_seed = 32'h5A;
    logic [2:0]  cfg_rate = 3'd0;
    logic        cfg_invert = 1'b0;
    logic        err_req = 1'b0;
    logic        tx_data;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    prbs_pattern_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .reload     (reload),
        .cfg_repeat (cfg_repeat),
        .cfg_len_m1 (cfg_len_m1),
        .cfg_tap    (cfg_tap),
        .cfg_seed   (cfg_seed),
        .cfg_rate   (cfg_rate),
        .cfg_invert (cfg_invert),
        .err_req    (err_req),
        .tx_data    (tx_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic        m_stage [32];
    logic        m_r1, m_r2, m_tx, m_pend;
    int          m_cnt;

    function automatic int dec_limit(input int code);
        int v = 1;
        for (int i = 0; i < code; i++) v = v * 10;
        return v;
    endfunction

    always @(posedge clk) begin : ref_model
        logic nxt [32];
        logic head, hit, rise, any;
        int   L;
        if (!rst_n) begin
            foreach (m_stage[i]) m_stage[i] = 1'b0;
            m_r1 = 0; m_r2 = 0; m_tx = 0; m_pend = 0; m_cnt = 0;
        end else begin
            L    = int'(cfg_len_m1) + 1;
            rise = m_r1 && !m_r2;
            head = m_stage[L-1];
            foreach (nxt[i]) nxt[i] = m_stage[i];
            if (clk_en) begin
                hit  = (cfg_rate != 0) && (m_cnt + 1 >= dec_limit(int'(cfg_rate)));
                m_tx = head ^ cfg_invert ^ (hit || m_pend);
                m_cnt = hit ? 0 : m_cnt + 1;
                for (int i = 31; i > 0; i--) nxt[i] = m_stage[i-1];
                nxt[0] = cfg_repeat ? head : (head ^ m_stage[cfg_tap]);
                m_pend = err_req;
            end else begin
                m_pend = m_pend || err_req;
            end
            if (cfg_rate == 0) m_cnt = 0;
            if (rise) begin
                m_cnt = 0;
                any = 0;
                for (int i = 0; i < 32; i++) begin
                    nxt[i] = (i < L) ? cfg_seed[i] : 1'b0;
                    any = any | nxt[i];
                end
                if (!cfg_repeat && !any) nxt[0] = 1'b1;
            end
            foreach (m_stage[i]) m_stage[i] = nxt[i];
            m_r2 = m_r1;
            m_r1 = reload;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) check(cur_req, tx_data, m_tx);
    end

    // ---------------- stimulus helpers ----------------
    // returns at the negedge after edge k (the edge that first saw reload high)
    task automatic do_reload();
        @(negedge clk) reload = 1'b1;
        @(negedge clk) reload = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count ones over n bits starting with bit 0 of a fresh reload
    task automatic count_after_reload(input int n, output int ones);
        ones = 0;
        do_reload();
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ones += int'(tx_data);
        end
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int ones;
        // R1: reset state
        run(3);
        check("R1", tx_data, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1", tx_data, 1'b0);

        // R2: pseudorandom x^7 + x^6 + 1 with seed 0x5A
        cur_req = "R2";
        do_reload();
        run(300);
        cfg_len_m1 = 5'd22; cfg_tap = 5'd17; cfg_seed = 32'h00C0FFEE;
        do_reload();
        run(300);

        // R3 / R4: repetitive word 0xA5, length 8, explicit order
        cur_req = "R3";
        cfg_repeat = 1'b1; cfg_len_m1 = 5'd7; cfg_seed = 32'hA5;
        do_reload();
        @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            check(i == 0 ? "R4" : "R3", tx_data, cfg_seed[7 - (i % 8)]);
        end

        // R7: same word inverted
        cur_req = "R7";
        cfg_invert = 1'b1;
        do_reload();
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check("R7", tx_data, ~cfg_seed[7 - (i % 8)]);
        end
        cfg_invert = 1'b0;

        // R5: all-zero pseudorandom seed must still toggle
        cur_req = "R5";
        cfg_repeat = 1'b0; cfg_len_m1 = 5'd6; cfg_tap = 5'd5; cfg_seed = 32'h80;
        count_after_reload(60, ones);
        check("R5", ones > 0 && ones < 60, 1'b1);

        // R6: gapped clock
        cur_req = "R6";
        cfg_seed = 32'h3;
        do_reload();
        run(5);
        @(negedge clk) clk_en = 1'b0;
        begin
            logic held;
            @(negedge clk) held = tx_data;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                check("R6", tx_data, held);
            end
        end
        for (int i = 0; i < 200; i++) begin
            @(negedge clk) clk_en = (($urandom % 3) != 0);
        end
        clk_en = 1'b1;

        // R8: decimal rates on an all-zero repetitive word of length 4
        cur_req = "R8";
        cfg_repeat = 1'b1; cfg_len_m1 = 5'd3; cfg_seed = 32'h0;
        cfg_rate = 3'd1;
        count_after_reload(40, ones);
        check_int("R8", ones, 4);
        cfg_rate = 3'd2;
        count_after_reload(300, ones);
        check_int("R8", ones, 3);
        cfg_rate = 3'd0;
        count_after_reload(100, ones);
        check_int("R8", ones, 0);

        // R9 / R10: one requested error on a recirculating zero word
        cur_req = "R9";
        do_reload();
        run(4);
        @(negedge clk) err_req = 1'b1;
        @(negedge clk) err_req = 1'b0;
        ones = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            ones += int'(tx_data);
        end
        check_int("R10", ones, 1);
        // request held across a gap
        @(negedge clk) clk_en = 1'b0; err_req = 1'b1;
        @(negedge clk) err_req = 1'b0;
        run(3);
        check("R9", tx_data, 1'b0);
        @(negedge clk) clk_en = 1'b1;
        @(negedge clk);
        check("R9", tx_data, 1'b1);
        @(negedge clk);
        check("R9", tx_data, 1'b0);
        // R10 on a pseudorandom stream: model compares the bits after the flip
        cur_req = "R10";
        cfg_repeat = 1'b0; cfg_len_m1 = 5'd14; cfg_tap = 5'd13; cfg_seed = 32'h1234;
        do_reload();
        run(20);
        @(negedge clk) err_req = 1'b1;
        @(negedge clk) err_req = 1'b0;
        run(100);

        // R11: request coincides with the automatic error at bit 9
        cur_req = "R11";
        cfg_repeat = 1'b1; cfg_len_m1 = 5'd3; cfg_seed = 32'h0; cfg_rate = 3'd1;
        ones = 0;
        do_reload();
        for (int c = 1; c <= 21; c++) begin
            @(negedge clk);
            if (c >= 2) ones += int'(tx_data);
            if (c == 11) check("R11", tx_data, 1'b1);
            if (c == 9)  err_req = 1'b1;
            if (c == 10) err_req = 1'b0;
        end
        check_int("R11", ones, 2);
        cfg_rate = 3'd0;
        run(10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule